// File: doc/BRIEF.md
# SCL Fractional Rate Generator

This block derives the bit-timing strobe for an I2C master from a 100 MHz system clock. A phase accumulator grows by an increment each active cycle. Whenever it reaches or passes a modulus of DEC+1 it drops by that modulus and emits a one-cycle `tick`. Each tick flips `scl_phase`, so the nominal SCL frequency is f_clk × INC / (2 × (DEC+1)). Ratios that are not whole numbers are therefore possible.

Two configuration words share one layout: one for standard/fast operation and one for high-speed operation. Both are written while the block is stopped. The master's engine raises `run` to start the timebase and lowers it to stop. A controller with four states sequences the block. STOPPED accepts configuration and waits for `run`. PRIME loads the chosen word into working registers. ACTIVE accumulates and ticks. MUTE is entered when the chosen increment is zero and produces nothing. Transitions: STOPPED→PRIME on `run`; PRIME→ACTIVE (increment non-zero) or PRIME→MUTE (increment zero); any state→STOPPED when `run` is low.

Top module: `scl_frac_divider`

## Requirements
- R1: During and after reset, `tick` and `scl_phase` are 0 and the block is stopped.
- R2: A configuration word carries INC in bits [16 +: INC_W] and DEC in bits [0 +: DEC_W]. `wr_std` stores the standard/fast word and `wr_hs` stores the high-speed word.
- R3: Configuration writes take effect only while the block is stopped. Writes made while running change neither word, as seen after a later restart.
- R4: With `run` sampled high while stopped, there are two priming edges, and the first accumulation happens on the third edge.
- R5: For INC ≤ DEC+1, after n accumulation edges exactly floor(n×INC/(DEC+1)) ticks have been issued, each one cycle wide, one per edge at most.
- R6: `scl_phase` toggles on every tick and on nothing else. With INC=1, DEC=499 the half period is 500 cycles (100 kHz at 100 MHz). With INC=1, DEC=124 it is 125 cycles (400 kHz).
- R7: `hs_sel`=1 selects the high-speed word and 0 selects the standard word. `hs_sel` is sampled on the edge where `run` is first seen high, and later changes have no effect until the next start.
- R8: A selected word with INC=0 produces no ticks, and `scl_phase` stays 0.
- R9: A selected word with INC > DEC+1 saturates: a tick on every accumulation edge.
- R10: On the edge where `run` is sampled low, `tick` and `scl_phase` clear and the accumulator returns to zero, so a restart repeats the tick pattern from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Run enable; low stops and clears |
| hs_sel | input | 1 | 1 selects the high-speed word at start |
| wr_std | input | 1 | Write strobe for the standard/fast word |
| wr_hs | input | 1 | Write strobe for the high-speed word |
| wr_data | input | CFG_W | Configuration word (INC at bit 16, DEC at bit 0) |
| tick | output | 1 | One-cycle bit-timing strobe |
| scl_phase | output | 1 | Nominal SCL level, toggled per tick |

## Verification
The bench builds the block with its default widths: a 32-bit word, 12-bit INC and 12-bit DEC fields. This lets it program the real 100 kHz and 400 kHz settings (DEC=499 and 124) as well as a high-speed word with a non-unit increment (41/152), all on whole periods. Random words with DEC below 64 wrap the accumulator many times per run. Their increments span zero, fractional values and values above the modulus, which reaches the MUTE state and the saturating case alongside ordinary fractional stepping.

// File: rtl/scl_div_pkg.sv
`timescale 1ns/1ps
package scl_div_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_PRIME   = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_MUTE    = 2'd3
    } div_state_e;

    typedef enum logic {
        MODE_STD = 1'b0,
        MODE_HS  = 1'b1
    } div_mode_e;

    localparam int NUM_WORDS = 2;

endpackage

// File: rtl/scl_cfg_bank.sv
`timescale 1ns/1ps
module scl_cfg_bank
    import scl_div_pkg::*;
#(
    parameter int CFG_W   = 32,
    parameter int INC_W   = 12,
    parameter int DEC_W   = 12,
    parameter int INC_LSB = 16,
    parameter int DEC_LSB = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             wr_std_i,
    input  logic             wr_hs_i,
    input  logic [CFG_W-1:0] wr_data_i,
    input  div_mode_e        mode_i,
    output logic [INC_W-1:0] sel_inc_o,
    output logic [DEC_W-1:0] sel_dec_o
);

    logic [NUM_WORDS-1:0] strobe;
    logic [INC_W-1:0]     inc_q [NUM_WORDS];
    logic [DEC_W-1:0]     dec_q [NUM_WORDS];

    assign strobe = {wr_hs_i, wr_std_i};

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                inc_q[g] <= '0;
                dec_q[g] <= '0;
            end else if (accept_i && strobe[g]) begin
                inc_q[g] <= wr_data_i[INC_LSB +: INC_W];
                dec_q[g] <= wr_data_i[DEC_LSB +: DEC_W];
            end
        end

        // R3: stored words are frozen whenever writes are not accepted
        assert_word_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !accept_i |=> ($stable(inc_q[g]) && $stable(dec_q[g])));
    end

    always_comb begin
        unique case (mode_i)
            MODE_HS: begin
                sel_inc_o = inc_q[1];
                sel_dec_o = dec_q[1];
            end
            default: begin
                sel_inc_o = inc_q[0];
                sel_dec_o = dec_q[0];
            end
        endcase
    end

endmodule

// File: rtl/scl_div_ctrl.sv
`timescale 1ns/1ps
module scl_div_ctrl
    import scl_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       hs_sel_i,
    input  logic       inc_zero_i,
    output div_mode_e  mode_o,
    output logic       accept_o,
    output logic       load_o,
    output logic       en_o,
    output logic       clr_o
);

    div_state_e state_q, state_d;
    div_mode_e  mode_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (run_i) state_d = ST_PRIME;
            ST_PRIME:   state_d = inc_zero_i ? ST_MUTE : ST_ACTIVE;
            ST_ACTIVE:  state_d = ST_ACTIVE;
            ST_MUTE:    state_d = ST_MUTE;
            default:    state_d = ST_STOPPED;
        endcase
        if (!run_i) state_d = ST_STOPPED;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // mode latch: taken on the edge where run is first seen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_STD;
        end else if (state_q == ST_STOPPED && run_i) begin
            mode_q <= hs_sel_i ? MODE_HS : MODE_STD;
        end
    end

    // outputs
    always_comb begin
        accept_o = 1'b0;
        load_o   = 1'b0;
        en_o     = 1'b0;
        clr_o    = !run_i;
        unique case (state_q)
            ST_STOPPED: accept_o = 1'b1;
            ST_PRIME:   load_o   = run_i;
            ST_ACTIVE:  en_o     = run_i;
            ST_MUTE:    en_o     = 1'b0;
            default:    accept_o = 1'b0;
        endcase
    end

    assign mode_o = mode_q;

    // R10: a low run always returns the controller to STOPPED
    assert_stop_on_low_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state_q == ST_STOPPED));

    // R4: PRIME is only ever entered from STOPPED
    assert_prime_from_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |-> ($past(state_q) == ST_STOPPED));

    // R4: ACTIVE is reached only through PRIME
    assert_active_after_prime_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) |-> ($past(state_q) == ST_PRIME || $past(state_q) == ST_ACTIVE));

    // R7: mode cannot change outside STOPPED
    assert_mode_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_STOPPED) |-> $stable(mode_q));

endmodule

// File: rtl/scl_phase_acc.sv
`timescale 1ns/1ps
module scl_phase_acc #(
    parameter int INC_W = 12,
    parameter int DEC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic             en_i,
    input  logic [INC_W-1:0] inc_i,
    input  logic [DEC_W-1:0] dec_i,
    output logic             tick_o,
    output logic             phase_o
);

    localparam int ACC_W = DEC_W + 1;
    localparam int SUM_W = ((INC_W > DEC_W) ? INC_W : DEC_W) + 2;

    logic [INC_W-1:0] inc_q;
    logic [ACC_W-1:0] mod_q;
    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] sum_w, mod_w, inc_w;
    logic             wrap_w, sat_w;

    assign inc_w  = SUM_W'(inc_q);
    assign mod_w  = SUM_W'(mod_q);
    assign sum_w  = SUM_W'(acc_q) + inc_w;
    assign wrap_w = (sum_w >= mod_w);
    assign sat_w  = (inc_w >= mod_w);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inc_q   <= '0;
            mod_q   <= ACC_W'(1);
            acc_q   <= '0;
            tick_o  <= 1'b0;
            phase_o <= 1'b0;
        end else if (clr_i) begin
            acc_q   <= '0;
            tick_o  <= 1'b0;
            phase_o <= 1'b0;
        end else if (load_i) begin
            inc_q   <= inc_i;
            mod_q   <= {1'b0, dec_i} + ACC_W'(1);
            acc_q   <= '0;
            tick_o  <= 1'b0;
        end else if (en_i) begin
            if (wrap_w) begin
                acc_q   <= sat_w ? '0 : ACC_W'(sum_w - mod_w);
                tick_o  <= 1'b1;
                phase_o <= ~phase_o;
            end else begin
                acc_q   <= ACC_W'(sum_w);
                tick_o  <= 1'b0;
            end
        end else begin
            tick_o <= 1'b0;
        end
    end

    // R5: residue always stays below the modulus
    assert_acc_below_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < mod_q);

    // R5: a tick only follows an enabled accumulation cycle
    assert_tick_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(en_i));

    // R6: the phase flips exactly when a tick is issued
    assert_phase_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (phase_o != $past(phase_o)));
    assert_phase_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_o && !$past(clr_i)) |-> $stable(phase_o));

    // R8: a zero increment never ticks
    assert_zero_inc_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc_q) == '0 && !$past(load_i)) |-> !tick_o);

    // R10: clearing empties the accumulator and outputs
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (acc_q == '0 && !tick_o && !phase_o));

endmodule

// File: rtl/scl_frac_divider.sv
`timescale 1ns/1ps
module scl_frac_divider
    import scl_div_pkg::*;
#(
    parameter int CFG_W = 32,
    parameter int INC_W = 12,
    parameter int DEC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hs_sel,
    input  logic             wr_std,
    input  logic             wr_hs,
    input  logic [CFG_W-1:0] wr_data,
    output logic             tick,
    output logic             scl_phase
);

    localparam int INC_LSB = 16;
    localparam int DEC_LSB = 0;

    div_mode_e        mode;
    logic             accept, load, en, clr;
    logic [INC_W-1:0] sel_inc;
    logic [DEC_W-1:0] sel_dec;
    logic             inc_zero;

    assign inc_zero = (sel_inc == '0);

    scl_cfg_bank #(
        .CFG_W   (CFG_W),
        .INC_W   (INC_W),
        .DEC_W   (DEC_W),
        .INC_LSB (INC_LSB),
        .DEC_LSB (DEC_LSB)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .wr_std_i  (wr_std),
        .wr_hs_i   (wr_hs),
        .wr_data_i (wr_data),
        .mode_i    (mode),
        .sel_inc_o (sel_inc),
        .sel_dec_o (sel_dec)
    );

    scl_div_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .hs_sel_i   (hs_sel),
        .inc_zero_i (inc_zero),
        .mode_o     (mode),
        .accept_o   (accept),
        .load_o     (load),
        .en_o       (en),
        .clr_o      (clr)
    );

    scl_phase_acc #(
        .INC_W (INC_W),
        .DEC_W (DEC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .load_i  (load),
        .en_i    (en),
        .inc_i   (sel_inc),
        .dec_i   (sel_dec),
        .tick_o  (tick),
        .phase_o (scl_phase)
    );

    // R1: outputs are idle in the first cycle after reset
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!tick && !scl_phase));

endmodule

// File: tb/scl_frac_divider_test.sv
`timescale 1ns/1ps
module scl_frac_divider_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        hs_sel = 1'b0;
    logic        wr_std = 1'b0;
    logic        wr_hs = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick;
    logic        scl_phase;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    scl_frac_divider uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .hs_sel    (hs_sel),
        .wr_std    (wr_std),
        .wr_hs     (wr_hs),
        .wr_data   (wr_data),
        .tick      (tick),
        .scl_phase (scl_phase)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // expected tick total after n accumulation edges
    function automatic longint exp_ticks(input longint n, input longint inc, input longint dec);
        longint m = dec + 1;
        if (n <= 0) return 0;
        if (inc >= m) return n;
        return (n * inc) / m;
    endfunction

    // R2: INC at bit 16, DEC at bit 0
    task automatic write_word(input bit hs, input int inc, input int dec);
        wr_data = (32'(inc) << 16) | 32'(dec);
        wr_hs   = hs;
        wr_std  = !hs;
        @(posedge clk); @(negedge clk);
        wr_hs   = 1'b0;
        wr_std  = 1'b0;
    endtask

    task automatic run_pattern(input int inc, input int dec, input int ncyc, input bit hs,
                               input bit disturb, input string req);
        int     mism = 0;
        longint first_act = 0, first_exp = 0;
        longint seen = 0;
        hs_sel = hs;
        run    = 1'b1;
        for (int k = 1; k <= ncyc; k++) begin
            longint n = k - 2;
            longint et, ep;
            @(posedge clk); @(negedge clk);
            et = (n >= 1) ? exp_ticks(n, inc, dec) - exp_ticks(n - 1, inc, dec) : 0;
            ep = (n >= 1) ? exp_ticks(n, inc, dec) % 2 : 0;
            if (tick) seen++;
            if (longint'(tick) != et || longint'(scl_phase) != ep) begin
                if (mism == 0) begin
                    first_act = k * 10 + longint'(tick) * 2 + longint'(scl_phase);
                    first_exp = k * 10 + et * 2 + ep;
                end
                mism++;
            end
            // R3/R7: writes and a mode flip while running must not matter
            if (disturb && k == ncyc / 2) begin
                wr_data = $urandom;
                wr_std  = 1'b1;
                wr_hs   = 1'b1;
                hs_sel  = ~hs;
            end else begin
                wr_std  = 1'b0;
                wr_hs   = 1'b0;
            end
        end
        check(mism == 0, req, "tick/phase pattern (cycle*10+tick*2+phase)", first_act, first_exp);
        check(seen == exp_ticks(ncyc - 2, inc, dec), "R6", "tick total over run", seen,
              exp_ticks(ncyc - 2, inc, dec));
    endtask

    task automatic stop_check();
        run = 1'b0;
        @(posedge clk); @(negedge clk);
        check(!tick && !scl_phase, "R10", "outputs after stop", {tick, scl_phase}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        @(negedge clk);
        check(!tick && !scl_phase, "R1", "outputs in reset", {tick, scl_phase}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tick && !scl_phase, "R1", "outputs after reset", {tick, scl_phase}, 0);

        // 100 kHz standard word, high-speed word zero (R2, R4, R5, R6)
        write_word(1'b1, 0, 0);
        write_word(1'b0, 1, 499);
        run_pattern(1, 499, 2102, 1'b0, 1'b0, "R5");
        stop_check();

        // 400 kHz, with writes attempted while running (R3)
        write_word(1'b0, 1, 124);
        run_pattern(1, 124, 700, 1'b0, 1'b1, "R3");
        stop_check();
        // restart without rewriting: same word, pattern from the start (R3, R10)
        run_pattern(1, 124, 400, 1'b0, 1'b0, "R10");
        stop_check();

        // high-speed word with fractional ratio; hs_sel flips mid-run (R7)
        write_word(1'b1, 41, 152);
        run_pattern(41, 152, 800, 1'b1, 1'b1, "R7");
        stop_check();

        // zero increment selects MUTE (R8)
        write_word(1'b0, 0, 20);
        run_pattern(0, 20, 300, 1'b0, 1'b0, "R8");
        check(!scl_phase, "R8", "phase stays low", scl_phase, 0);
        stop_check();

        // saturating increment (R9)
        write_word(1'b0, 9, 3);
        run_pattern(9, 3, 60, 1'b0, 1'b0, "R9");
        stop_check();

        // random words mixed across both modes (R5)
        for (int i = 0; i < 16; i++) begin
            int dec = int'($urandom_range(0, 63));
            int inc = int'($urandom_range(0, dec + 3));
            bit hs  = bit'($urandom_range(0, 1));
            write_word(hs, inc, dec);
            run_pattern(inc, dec, 160, hs, 1'b0, "R5");
            stop_check();
        end

        summary();
        $finish;
    end

endmodule